// File: doc/BRIEF.md
# ROM Checksum Self-Test Sequencer

This block verifies the contents of a 128-byte read-only memory built from four 32-byte banks that share one 8-bit data bus. A single-cycle start pulse begins a linear walk from address 0x00 upwards. For each address the sequencer drives the 7-bit address together with a one-hot bank enable decoded from the upper two address bits, so that exactly one bank drives the bus. Every byte read from a data location is XOR-folded into a running byte sum.

The top location, 0x7F, holds the expected checksum: the XOR of all other locations. The sequencer reads it as the reference value and does not fold it into the sum. Once the walk ends, the sum is compared with the reference. A one-cycle done pulse then reports the outcome on a pass or a fault flag, and that flag stays up until the next accepted start. Memory reads are assumed to have one clock of latency.

Top module: `romXsumCheck`

## Requirements
- R1: After a synchronous active-high reset, busy, done, pass and fault are low and all four bank enables are low.
- R2: A start pulse sampled while idle sets the address to 0x00. The address then rises by one every cycle up to 0x7F, so each address is driven exactly once in ascending order.
- R3: While a read is issued exactly one bank enable is high: bit 0 for 0x00–0x1F, bit 1 for 0x20–0x3F, bit 2 for 0x40–0x5F, bit 3 for 0x60–0x7F (the address bits 6:5 select it). When no read is issued, all enables are low.
- R4: The data bus is sampled on the clock edge one cycle after its address was driven. The bytes at 0x00 through 0x7E are XOR-combined into the running sum, which starts at zero.
- R5: The byte at 0x7F is taken as the expected checksum and is not included in the running sum.
- R6: An equal sum and expected byte gives pass=1, fault=0. Any difference gives fault=1, pass=0. A single flipped bit at any of the 128 locations yields fault.
- R7: done is high for exactly one cycle per check. pass and fault keep their value after done and are cleared in the cycle after the next accepted start.
- R8: A start pulse while busy is ignored: the walk continues undisturbed, produces one done, and ends at the same cycle as an undisturbed run.
- R9: With the start pulse sampled on edge 0, done is high in the cycle after edge 130 (128 reads plus two cycles to compare). busy is high from edge 0 until done rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Begin a check when idle |
| memData | input | 8 | Shared memory data bus, valid one cycle after the address |
| memAddr | output | 7 | Memory address |
| bankEn | output | 4 | One-hot bank enables |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Sum matched the stored checksum |
| fault | output | 1 | Sum did not match the stored checksum |

## Verification
The bench flips one bit at every one of the 128 locations in turn, one run per location. A design that skipped a location or decoded the wrong bank would report pass for some of those runs. The checksum byte itself is among the flipped locations, and a correct checksum is nonzero with random data. Folding 0x7F into the sum therefore turns every clean run into a fault. Off-by-one latency on the data bus would shift every fold by one address and break both results. A monitor checks the address order and the bank enables on every cycle. The bench also times each run to the exact cycle, with and without a stray start mid-walk, which exposes a restarted walk or a stretched done pulse.

// File: rtl/xsum_pkg.sv
package xsum_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WALK  = 2'd1,
    SEQ_DRAIN = 2'd2,
    SEQ_CHECK = 2'd3
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // reset address, sum and read pipeline
    logic issueRead;  // drive current address and bank enable this cycle
  } seqStrobes_t;

endpackage

// File: rtl/xsumDatapath.sv
module xsumDatapath
  import xsum_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  seqStrobes_t               strobes,
  input  logic [DATA_W-1:0]         memData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [(1 << SEL_W)-1:0]   bankEn,
  output logic                      atLast,
  output logic                      sumMatch
);

  localparam int NUM_BANKS = 1 << SEL_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addrReg;
  logic              pendValid;
  logic              pendIsCk;
  logic [DATA_W-1:0] sumReg;
  logic [DATA_W-1:0] expReg;

  assign atLast  = (addrReg == LAST_ADDR);
  assign memAddr = addrReg;

  // Address counter
  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      addrReg <= '0;
    end else if (strobes.issueRead && !atLast) begin
      addrReg <= ADDR_W'(addrReg + 1'b1);
    end
  end

  // Read-latency pipeline: data arrives one cycle after the address
  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      pendValid <= 1'b0;
      pendIsCk  <= 1'b0;
    end else begin
      pendValid <= strobes.issueRead;
      pendIsCk  <= strobes.issueRead && atLast;
    end
  end

  // Running XOR sum and captured reference byte
  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      sumReg <= '0;
      expReg <= '0;
    end else if (pendValid) begin
      if (pendIsCk) begin
        expReg <= memData;
      end else begin
        sumReg <= sumReg ^ memData;
      end
    end
  end

  assign sumMatch = (sumReg == expReg);

  // Bank decode from the upper address bits
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankEn[b] = strobes.issueRead &&
                       (addrReg[ADDR_W-1 -: SEL_W] == SEL_W'(b));

    p_bank_range_r3: assert property (@(posedge clk) disable iff (rst)
      bankEn[b] |-> (memAddr[ADDR_W-1 -: SEL_W] == SEL_W'(b)));
  end

  p_bank_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bankEn));

  p_bank_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.issueRead |-> (bankEn == '0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.issueRead && !atLast && !strobes.clearAll)
      |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  p_sum_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pendValid && pendIsCk && !strobes.clearAll) |=> $stable(sumReg));

endmodule

// File: rtl/xsumControl.sv
module xsumControl
  import xsum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startPulse,
  input  logic        atLast,
  input  logic        sumMatch,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done,
  output logic        pass,
  output logic        fault
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext        = state;
    strobes.clearAll  = 1'b0;
    strobes.issueRead = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (startPulse) begin
          strobes.clearAll = 1'b1;
          stateNext        = SEQ_WALK;
        end
      end
      SEQ_WALK: begin
        strobes.issueRead = 1'b1;
        if (atLast) stateNext = SEQ_DRAIN;
      end
      SEQ_DRAIN: stateNext = SEQ_CHECK;
      SEQ_CHECK: stateNext = SEQ_IDLE;
      default:   stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
      fault <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == SEQ_CHECK);
      if (strobes.clearAll) begin
        pass  <= 1'b0;
        fault <= 1'b0;
      end else if (state == SEQ_CHECK) begin
        pass  <= sumMatch;
        fault <= !sumMatch;
      end
    end
  end

  assign busy = (state != SEQ_IDLE);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_verdict_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pass && fault));

  p_verdict_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fault));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && startPulse && state != SEQ_CHECK) |=> busy);

endmodule

// File: rtl/romXsumCheck.sv
module romXsumCheck
  import xsum_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    startPulse,
  input  logic [DATA_W-1:0]       memData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [(1 << SEL_W)-1:0] bankEn,
  output logic                    busy,
  output logic                    done,
  output logic                    pass,
  output logic                    fault
);

  seqStrobes_t strobes;
  logic        atLast;
  logic        sumMatch;

  xsumControl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .atLast     (atLast),
    .sumMatch   (sumMatch),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fault      (fault)
  );

  xsumDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memData  (memData),
    .memAddr  (memAddr),
    .bankEn   (bankEn),
    .atLast   (atLast),
    .sumMatch (sumMatch)
  );

endmodule

// File: tb/romXsumCheck_tb.sv
module romXsumCheck_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NLOC       = 128;
  localparam int RUN_CYCLES = 130;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startPulse = 1'b0;
  logic [7:0] memData = 8'h00;
  logic [6:0] memAddr;
  logic [3:0] bankEn;
  logic       busy, done, pass, fault;

  logic [7:0] mem [NLOC];

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;

  // Monitor state
  bit monOn = 1'b0;
  int monReads = 0;
  int monErr = 0;
  int monNext = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  romXsumCheck u_dut (
    .clk(clk), .rst(rst), .startPulse(startPulse), .memData(memData),
    .memAddr(memAddr), .bankEn(bankEn), .busy(busy), .done(done),
    .pass(pass), .fault(fault)
  );

  // Banked memory model: enabled bank drives the shared bus, one cycle later
  function automatic logic [7:0] busValue(input logic [3:0] en, input logic [6:0] a);
    logic [7:0] v = 8'h00;
    for (int b = 0; b < 4; b++)
      if (en[b]) v = v | mem[{b[1:0], a[4:0]}];
    return v;
  endfunction

  always @(posedge clk) begin
    memData <= busValue(bankEn, memAddr);
    cycleCount <= cycleCount + 1;
  end

  // Per-cycle monitor of address order and bank decode (R2, R3)
  always @(negedge clk) begin
    if (monOn) begin
      if (bankEn != 4'b0000) begin
        if (bankEn != (4'b0001 << memAddr[6:5])) monErr++;
        if (int'(memAddr) != monNext) monErr++;
        monNext++;
        monReads++;
      end
    end
    if (!busy && bankEn != 4'b0000) monErr++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void sealChecksum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < NLOC-1; i++) s = s ^ mem[i];
    mem[NLOC-1] = s;
  endfunction

  // One check run; extraAt >= 0 pulses start again at that cycle of the walk
  task automatic runOnce(input int extraAt, output int cyc, output bit pOut,
                         output bit fOut, output bit pulseOk);
    cyc = 0;
    monReads = 0; monErr = 0; monNext = 0; monOn = 1'b1;
    @(negedge clk); startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk); startPulse = 1'b0;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      startPulse = (cyc == extraAt);
      if (done || cyc > 400) break;
    end
    startPulse = 1'b0;
    pOut = pass; fOut = fault;
    @(negedge clk);
    pulseOk = !done && (pass == pOut) && (fault == fOut);
    monOn = 1'b0;
  endtask

  // Watchdog
  initial begin
    wait (cycleCount > WATCHDOG);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycleCount, WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc;
    bit p, f, ok;
    logic [7:0] saved;

    for (int i = 0; i < NLOC; i++) mem[i] = 8'(($urandom));
    sealChecksum();

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "pass", pass, 0);
    check("R1", "fault", fault, 0);
    check("R1", "bankEn", bankEn, 0);

    // Clean random image (R2, R3, R4, R5, R6, R7, R9)
    runOnce(-1, cyc, p, f, ok);
    check("R9", "run length", cyc, RUN_CYCLES);
    check("R6", "pass clean", p, 1);
    check("R6", "fault clean", f, 0);
    check("R7", "single done and hold", ok, 1);
    check("R2", "reads seen", monReads, NLOC);
    check("R3", "decode/order errors", monErr, 0);
    check("R5", "checksum nonzero in image", mem[NLOC-1] != 8'h00, 1);
    repeat (5) @(negedge clk);
    check("R7", "pass held", pass, 1);

    // R7: accepted start clears the verdict in the following cycle
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    check("R7", "pass cleared on start", pass, 0);
    check("R9", "busy after start", busy, 1);
    wait (done); @(negedge clk); @(negedge clk);

    // R8: stray start mid-walk
    runOnce(50, cyc, p, f, ok);
    check("R8", "run length with stray start", cyc, RUN_CYCLES);
    check("R8", "pass with stray start", p, 1);
    check("R8", "address order with stray start", monErr, 0);

    // R6/R4: flip one bit at every location, one run each
    for (int loc = 0; loc < NLOC; loc++) begin
      saved = mem[loc];
      mem[loc] = saved ^ (8'h01 << (loc % 8));
      runOnce(-1, cyc, p, f, ok);
      check(loc == NLOC-1 ? "R5" : "R6", $sformatf("fault at loc %0d", loc), f, 1);
      if (p) check("R6", $sformatf("pass low at loc %0d", loc), p, 0);
      if (monErr != 0) check("R3", "decode errors in sweep", monErr, 0);
      mem[loc] = saved;
    end

    // R4: all-zero image passes
    for (int i = 0; i < NLOC; i++) mem[i] = 8'h00;
    runOnce(-1, cyc, p, f, ok);
    check("R4", "zero image pass", p, 1);

    // R4/R5: all-0xFF data, 127 odd bytes give 0xFF checksum
    for (int i = 0; i < NLOC; i++) mem[i] = 8'hFF;
    runOnce(-1, cyc, p, f, ok);
    check("R5", "ones image pass", p, 1);
    mem[NLOC-1] = 8'h00;
    runOnce(-1, cyc, p, f, ok);
    check("R6", "ones image bad checksum fault", f, 1);

    // R1: reset mid-walk returns to idle
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", "busy after reset", busy, 0);
    check("R1", "bankEn after reset", bankEn, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule